// File: doc/BRIEF.md
# Ring bracket access checker

This block judges a transfer through a segment descriptor against the protection rules of a ring-based memory system. A request arrives with the descriptor's three ring brackets, its gate flag, and its segment bound. It also carries the ring the request runs in, the segment numbers of the target and of the running procedure, and the 18-bit computed address. The block checks every rule in the same cycle. It collects each broken rule as its own bit of a 16-bit violation mask, so one access fault can report all the causes together.

A descriptor whose gate flag is clear is not a gate. A transfer through it stays in the caller's ring, so the block replaces the effective ring with the running procedure's ring. The transfer is also only legal when it stays inside the running procedure's own segment. The verdict (mask, fault request and adjusted ring) is registered. It appears for exactly one cycle after each request strobe, and the outputs are zero in any cycle that carries no result.

Top module: `seg_access_chk`

## Requirements
- R1: While reset is asserted (active low), and after it, until the first strobe, `res_valid`, `fault_req`, `viol_mask` and `ring_out` are all zero.
- R2: A strobe on `chk_valid` in a cycle gives `res_valid` high, with that request's verdict, in the following cycle only. In a cycle after a cycle without a strobe, `viol_mask`, `fault_req` and `ring_out` read zero. Back-to-back strobes give back-to-back verdicts.
- R3: Mask bit 0 is set when the bracket order lowest ≤ middle ≤ highest does not hold.
- R4: Mask bit 3 is set when the incoming effective ring is greater than the middle bracket. The ring used is the one before any replacement by R5.
- R5: When the gate flag is 0, `ring_out` equals the current procedure ring. When it is 1, `ring_out` equals the incoming effective ring.
- R6: Mask bit 4 is set when the gate flag is 0 and the target segment number differs from the current procedure segment number. A gate flag of 1 never sets bit 4.
- R7: Mask bit 15 is set when address bits 17:4 (the page index), read as an unsigned number, exceed the 14-bit bound. Equality does not set it.
- R8: `fault_req` is high exactly when the reported mask is nonzero. Mask bits 1, 2 and 5 through 14 are always 0.
- R9: Violations accumulate: every rule broken by one request shows in the same mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Request strobe, one cycle per check |
| brk_lo | input | 3 | Lowest ring bracket of the descriptor |
| brk_mid | input | 3 | Middle ring bracket |
| brk_hi | input | 3 | Highest ring bracket |
| gate_flag | input | 1 | Descriptor gate flag; 0 means not a gate |
| seg_bound | input | 14 | Highest legal page index of the segment |
| eff_ring | input | 3 | Effective ring of the request |
| cur_ring | input | 3 | Ring of the running procedure |
| tgt_seg | input | 15 | Target segment number |
| cur_seg | input | 15 | Running procedure's segment number |
| comp_addr | input | 18 | Computed address within the segment |
| res_valid | output | 1 | Verdict present this cycle |
| viol_mask | output | 16 | Accumulated violation bits |
| fault_req | output | 1 | Access-fault request |
| ring_out | output | 3 | Adjusted effective ring |

## Verification
Table vectors trip one rule at a time, so that each mask bit is shown to depend only on its own condition. Other vectors sit on the edges of those conditions: ring equal to the middle bracket, page index equal to the bound, and the largest bound and address. A gate-clear vector with a matching segment tells the ring replacement apart from the segment-mismatch bit. A gate-set vector with a mismatching segment shows that the mismatch is then ignored. A gate-clear vector whose incoming ring is above the bracket shows that bit 3 uses the ring before replacement. Finally, a vector that breaks every rule shows accumulation, and directed back-to-back strobes and idle cycles show the one-cycle result window.

// File: rtl/seg_access_chk.sv
module seg_access_chk #(
  parameter int RING_W    = 3,
  parameter int SEG_W     = 15,
  parameter int ADDR_W    = 18,
  parameter int BOUND_W   = 14,
  parameter int PAGE_SH   = 4,
  parameter int MASK_W    = 16,
  parameter int BIT_ORDER = 0,
  parameter int BIT_RING  = 3,
  parameter int BIT_GATE  = 4,
  parameter int BIT_BOUND = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_valid,
  input  logic [RING_W-1:0]  brk_lo,
  input  logic [RING_W-1:0]  brk_mid,
  input  logic [RING_W-1:0]  brk_hi,
  input  logic               gate_flag,
  input  logic [BOUND_W-1:0] seg_bound,
  input  logic [RING_W-1:0]  eff_ring,
  input  logic [RING_W-1:0]  cur_ring,
  input  logic [SEG_W-1:0]   tgt_seg,
  input  logic [SEG_W-1:0]   cur_seg,
  input  logic [ADDR_W-1:0]  comp_addr,
  output logic               res_valid,
  output logic [MASK_W-1:0]  viol_mask,
  output logic               fault_req,
  output logic [RING_W-1:0]  ring_out
);

  localparam logic [MASK_W-1:0] USED_BITS =
      (MASK_W'(1) << BIT_ORDER) | (MASK_W'(1) << BIT_RING) |
      (MASK_W'(1) << BIT_GATE)  | (MASK_W'(1) << BIT_BOUND);

  logic [BOUND_W-1:0] page_idx;
  logic [MASK_W-1:0]  mask_n;
  logic [RING_W-1:0]  ring_n;

  assign page_idx = comp_addr[PAGE_SH +: BOUND_W];
  assign ring_n   = gate_flag ? eff_ring : cur_ring;

  always_comb begin
    mask_n = '0;
    if (!((brk_lo <= brk_mid) && (brk_mid <= brk_hi))) mask_n[BIT_ORDER] = 1'b1;
    if (eff_ring > brk_mid)                            mask_n[BIT_RING]  = 1'b1;
    if (!gate_flag && (tgt_seg != cur_seg))            mask_n[BIT_GATE]  = 1'b1;
    if (page_idx > seg_bound)                          mask_n[BIT_BOUND] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      viol_mask <= '0;
      fault_req <= 1'b0;
      ring_out  <= '0;
    end else begin
      res_valid <= chk_valid;
      viol_mask <= chk_valid ? mask_n : '0;
      fault_req <= chk_valid && (|mask_n);
      ring_out  <= chk_valid ? ring_n : '0;
    end
  end

  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(chk_valid)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (viol_mask == '0 && !fault_req && ring_out == '0)); // R2

  AST_FAULT_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req == (viol_mask != '0)); // R8

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_mask & ~USED_BITS) == '0); // R8

  AST_GATE_KEEPS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && gate_flag) |=> (ring_out == $past(eff_ring))); // R5

  AST_GATELESS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !gate_flag) |=> (ring_out == $past(cur_ring))); // R5

  AST_GATE_NO_SEG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && gate_flag) |=> !viol_mask[BIT_GATE]); // R6

endmodule

// File: tb/seg_access_chk_tb.sv
module seg_access_chk_tb;

  typedef struct packed {
    logic [2:0]  lo, mid, hi;
    logic        gate;
    logic [13:0] bnd;
    logic [2:0]  eff, cur;
    logic [14:0] tseg, cseg;
    logic [17:0] addr;
    logic [15:0] mask;
    logic [2:0]  ring;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd1,3'd2,3'd3,1'b1,14'd10,3'd2,3'd0,15'd5,15'd7,18'h000AF,16'h0000,3'd2},    // R7 page == bound
    '{3'd3,3'd2,3'd4,1'b1,14'd10,3'd1,3'd0,15'd1,15'd1,18'h00000,16'h0001,3'd1},    // R3 lo>mid
    '{3'd0,3'd5,3'd4,1'b1,14'd10,3'd0,3'd0,15'd1,15'd1,18'h00000,16'h0001,3'd0},    // R3 mid>hi
    '{3'd0,3'd2,3'd4,1'b1,14'd10,3'd3,3'd1,15'd1,15'd1,18'h00000,16'h0008,3'd3},    // R4 eff>mid
    '{3'd0,3'd2,3'd4,1'b1,14'd10,3'd2,3'd1,15'd1,15'd1,18'h00000,16'h0000,3'd2},    // R4 eff==mid
    '{3'd0,3'd4,3'd4,1'b0,14'd10,3'd1,3'd5,15'd9,15'd9,18'h00000,16'h0000,3'd5},    // R5 replace
    '{3'd0,3'd4,3'd4,1'b0,14'd10,3'd1,3'd5,15'd9,15'd8,18'h00000,16'h0010,3'd5},    // R6 mismatch
    '{3'd0,3'd4,3'd4,1'b1,14'd10,3'd1,3'd5,15'd9,15'd8,18'h00000,16'h0000,3'd1},    // R6 gate set
    '{3'd0,3'd4,3'd4,1'b1,14'd10,3'd1,3'd0,15'd2,15'd2,18'h000B0,16'h8000,3'd1},    // R7 page>bound
    '{3'd4,3'd2,3'd1,1'b0,14'd0, 3'd7,3'd6,15'd1,15'd2,18'h3FFFF,16'h8019,3'd6},    // R9 all
    '{3'd0,3'd7,3'd7,1'b1,14'h3FFF,3'd7,3'd0,15'd3,15'd3,18'h3FFFF,16'h0000,3'd7},  // R7 max
    '{3'd0,3'd1,3'd1,1'b0,14'd10,3'd3,3'd0,15'd3,15'd3,18'h00000,16'h0008,3'd0}     // R4 pre-replace ring
  };

  logic        clk = 1'b0, rst_n = 1'b0, chk_valid = 1'b0;
  logic [2:0]  brk_lo = '0, brk_mid = '0, brk_hi = '0, eff_ring = '0, cur_ring = '0;
  logic        gate_flag = 1'b0;
  logic [13:0] seg_bound = '0;
  logic [14:0] tgt_seg = '0, cur_seg = '0;
  logic [17:0] comp_addr = '0;
  logic        res_valid, fault_req;
  logic [15:0] viol_mask;
  logic [2:0]  ring_out;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  seg_access_chk u_dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
    .brk_lo(brk_lo), .brk_mid(brk_mid), .brk_hi(brk_hi),
    .gate_flag(gate_flag), .seg_bound(seg_bound),
    .eff_ring(eff_ring), .cur_ring(cur_ring),
    .tgt_seg(tgt_seg), .cur_seg(cur_seg), .comp_addr(comp_addr),
    .res_valid(res_valid), .viol_mask(viol_mask),
    .fault_req(fault_req), .ring_out(ring_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    brk_lo = v.lo; brk_mid = v.mid; brk_hi = v.hi; gate_flag = v.gate;
    seg_bound = v.bnd; eff_ring = v.eff; cur_ring = v.cur;
    tgt_seg = v.tseg; cur_seg = v.cseg; comp_addr = v.addr;
  endtask

  task automatic check_verdict(input vec_t v, input int idx);
    chk($sformatf("R2 valid vec %0d", idx), {31'd0, res_valid}, 32'd1);
    chk($sformatf("R3/R4/R6/R7/R9 mask vec %0d", idx), {16'd0, viol_mask}, {16'd0, v.mask});
    chk($sformatf("R8 fault vec %0d", idx), {31'd0, fault_req}, {31'd0, (v.mask != 0)});
    chk($sformatf("R5 ring vec %0d", idx), {29'd0, ring_out}, {29'd0, v.ring});
  endtask

  task automatic check_idle(input string tag);
    chk({"R2 idle valid ", tag}, {31'd0, res_valid}, 32'd0);
    chk({"R2 idle mask ", tag}, {16'd0, viol_mask}, 32'd0);
    chk({"R2 idle fault ", tag}, {31'd0, fault_req}, 32'd0);
    chk({"R2 idle ring ", tag}, {29'd0, ring_out}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      chk_valid = 1'b1;
      @(negedge clk);
      check_verdict(VEC[i], i);
      chk_valid = 1'b0;
      drive(VEC[9]);
      @(negedge clk);
      check_idle($sformatf("after vec %0d", i));
    end

    // R2 back-to-back strobes
    drive(VEC[3]); chk_valid = 1'b1;
    @(negedge clk);
    check_verdict(VEC[3], 3);
    drive(VEC[6]);
    @(negedge clk);
    check_verdict(VEC[6], 6);
    chk_valid = 1'b0;
    @(negedge clk);
    check_idle("after back-to-back");

    // R1 reset mid-result clears outputs
    drive(VEC[9]); chk_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; chk_valid = 1'b0;
    @(negedge clk);
    check_idle("R1 reset clears");
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule